// File: doc/BRIEF.md
# Descriptor ring DMA engine

A single-channel DMA engine that executes 128-bit descriptors from a circular ring in memory. Software sets the ring base address and the ring size (in descriptors), then moves a head index forward. Whenever the head differs from the engine's tail index, the engine reads the descriptor at the tail, carries it out, and then advances the tail and a 17-bit completion counter. Four descriptor kinds exist: an empty operation, a line-granular memory copy, a 64-bit status write that can raise an interrupt, and a 32-bit general write.

All memory traffic goes through one request/acknowledge port that moves whole 64-byte lines. Reads return a full line. Writes carry a line of data with a per-byte strobe. Descriptor fetches read the line that holds the descriptor and pick the 16-byte slot out of it. A malformed descriptor (an unknown kind code, or a copy of zero lines) sets a sticky error flag and parks the engine until software drops `enable`.

The controller is a single state machine with these states: IDLE, FETCH, DECODE, CP_RD, CP_WR, WR_STAT, WR_GEN, RETIRE and HALT. Its transitions are:
- IDLE→FETCH when enable is high and head≠tail.
- FETCH→DECODE on acknowledge.
- DECODE→RETIRE for kind 0.
- DECODE→CP_RD for a copy with a non-zero length.
- DECODE→WR_STAT for kind 2.
- DECODE→WR_GEN for kind 3.
- DECODE→HALT for an unknown kind or a zero-length copy.
- CP_RD→CP_WR on acknowledge.
- CP_WR→CP_RD on acknowledge while lines remain.
- CP_WR→RETIRE on acknowledge of the last line.
- WR_STAT→RETIRE and WR_GEN→RETIRE on acknowledge.
- RETIRE→IDLE always.
- HALT→IDLE when enable is low.

Top module: `dma_ring_engine`

## Requirements
- R1: With `enable` high and `head_ptr` ≠ `tail_ptr`, the engine issues a line read at (`ring_base` + 16·tail) with the low 6 bits cleared. It takes the descriptor from byte slot address[5:4] of that line, with word0 in the lower 8 bytes. While head equals tail, no memory request is made.
- R2: The descriptor kind is word1[63:60]. Kind 0 retires with no memory access beyond its fetch.
- R3: Kind 1 copies. The source is word0[39:0], the destination is word1[39:0] and the line count is word0[59:46]. Line k is read from source+64k and then written with all 64 strobes to destination+64k. Lines are handled in rising order, one read before each write.
- R4: Kind 2 writes word0 (64 bits) to address word1[39:0]. The strobes are the 8 bytes starting at byte 8·addr[5:3]. `irq` is high for exactly one cycle at its retirement when word1[59] is 1, and stays low otherwise.
- R5: Kind 3 writes word0[31:0] to address word1[39:0] with the 4 strobes starting at byte 4·addr[5:2]. It never raises `irq`.
- R6: `tail_ptr` and `done_count` each advance by one only after the descriptor's last memory access has been acknowledged. `tail_ptr` wraps to 0 after `ring_size`−1. `done_count` is 17 bits and wraps modulo 2^17.
- R7: A kind code of 4 to 15 sets `err_flags[0]`. The engine then halts with no further requests and without advancing the tail. The flags clear, and the engine returns to idle, once `enable` is low.
- R8: A copy with a line count of 0 sets `err_flags[1]` and halts in the same way as R7.
- R9: Once `mem_req` is raised, it and its address, write flag, data and strobes stay unchanged until the cycle in which `mem_ack` is high.
- R10: While `enable` is low, no new descriptor fetch starts.
- R11: After reset, `tail_ptr`, `done_count` and `err_flags` are 0, and `mem_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel run enable |
| ring_base | input | 40 | Byte address of ring slot 0 (64-byte aligned) |
| ring_size | input | 17 | Ring length in descriptors (multiple of 4) |
| head_ptr | input | 17 | Software head index |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 40 | Line-aligned byte address |
| mem_wdata | output | 512 | Write line |
| mem_be | output | 64 | Per-byte write strobes |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 512 | Read line, valid with mem_ack |
| tail_ptr | output | 17 | Hardware tail index |
| done_count | output | 17 | Completed descriptor count |
| err_flags | output | 2 | Sticky errors: [0] bad kind, [1] zero-length copy |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The assertions take for granted that `ring_size` is non-zero and is not changed while the engine runs. They also assume `mem_ack` is only raised while a request is pending, and that `head_ptr` stays below `ring_size`. The stimulus sets the ring geometry before reset is released and never touches it afterwards. Its memory responder raises an acknowledge only against a live request, after a fixed two-cycle wait. Every head value it writes lies inside the eight-slot ring it uses.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;

    localparam int DESC_W      = 128;
    localparam int DESC_ADDR_W = 40;
    localparam int LEN_W       = 14;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_CP_RD,
        ST_CP_WR,
        ST_WR_STAT,
        ST_WR_GEN,
        ST_RETIRE,
        ST_HALT
    } eng_state_t;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_COPY = 2'd1,
        OP_STAT = 2'd2,
        OP_GEN  = 2'd3
    } op_t;

    typedef struct packed {
        logic                   known;
        op_t                    op;
        logic [DESC_ADDR_W-1:0] src;
        logic [DESC_ADDR_W-1:0] dst;
        logic [LEN_W-1:0]       lines;
        logic [63:0]            data;
        logic                   irq_req;
    } desc_t;

endpackage

// File: rtl/dma_desc_decode.sv
module dma_desc_decode
    import dma_ring_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output desc_t             dec
);

    logic [63:0] w0;
    logic [63:0] w1;
    logic [3:0]  code;

    always_comb begin
        w0          = raw[63:0];
        w1          = raw[127:64];
        code        = w1[63:60];
        dec.known   = (code < 4'd4);
        dec.op      = op_t'(code[1:0]);
        dec.src     = w0[DESC_ADDR_W-1:0];
        dec.dst     = w1[DESC_ADDR_W-1:0];
        dec.lines   = w0[59:46];
        dec.data    = w0;
        dec.irq_req = w1[59];
    end

endmodule

// File: rtl/dma_wr_pack.sv
module dma_wr_pack #(
    parameter int LINE_BYTES = 64
) (
    input  logic [63:0]                     data,
    input  logic [$clog2(LINE_BYTES)-1:0]   addr_lo,
    input  logic                            wide,
    output logic [LINE_BYTES*8-1:0]         wdata,
    output logic [LINE_BYTES-1:0]           be
);

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);

    logic [OFF_W-1:0] off;

    always_comb begin
        if (wide) begin
            off   = {addr_lo[OFF_W-1:3], 3'b000};
            wdata = LINE_W'(data) << {off, 3'b000};
            be    = LINE_BYTES'(8'hFF) << off;
        end else begin
            off   = {addr_lo[OFF_W-1:2], 2'b00};
            wdata = LINE_W'(data[31:0]) << {off, 3'b000};
            be    = LINE_BYTES'(4'hF) << off;
        end
    end

endmodule

// File: rtl/dma_ring_ptr.sv
module dma_ring_ptr #(
    parameter int IDX_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W-1:0] ring_size,
    output logic [IDX_W-1:0] tail,
    output logic [IDX_W-1:0] count
);

    logic [IDX_W-1:0] tail_inc;

    assign tail_inc = tail + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail  <= '0;
            count <= '0;
        end else if (adv) begin
            tail  <= (tail_inc == ring_size) ? '0 : tail_inc;
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dma_ring_engine.sv
module dma_ring_engine
    import dma_ring_pkg::*;
#(
    parameter int IDX_W      = 17,
    parameter int LINE_BYTES = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic [DESC_ADDR_W-1:0]    ring_base,
    input  logic [IDX_W-1:0]          ring_size,
    input  logic [IDX_W-1:0]          head_ptr,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [DESC_ADDR_W-1:0]    mem_addr,
    output logic [LINE_BYTES*8-1:0]   mem_wdata,
    output logic [LINE_BYTES-1:0]     mem_be,
    input  logic                      mem_ack,
    input  logic [LINE_BYTES*8-1:0]   mem_rdata,
    output logic [IDX_W-1:0]          tail_ptr,
    output logic [IDX_W-1:0]          done_count,
    output logic [1:0]                err_flags,
    output logic                      irq
);

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LA_W   = DESC_ADDR_W - OFF_W;
    localparam int SLOT_W = OFF_W - 4;

    eng_state_t          state, nxt;
    logic [DESC_W-1:0]   raw_q;
    desc_t               dec;
    logic [LA_W-1:0]     src_q, dst_q;
    logic [LEN_W-1:0]    left_q;
    logic [LINE_W-1:0]   line_q;
    logic [1:0]          err_q;
    logic                adv;

    logic [DESC_ADDR_W-1:0] fetch_byte;
    logic [SLOT_W-1:0]      fetch_slot;
    logic [LINE_W-1:0]      pk_wdata;
    logic [LINE_BYTES-1:0]  pk_be;

    assign fetch_byte = ring_base + (DESC_ADDR_W'(tail_ptr) << 4);
    assign fetch_slot = fetch_byte[OFF_W-1:4];

    dma_desc_decode u_dec (
        .raw (raw_q),
        .dec (dec)
    );

    dma_wr_pack #(.LINE_BYTES(LINE_BYTES)) u_pack (
        .data    (dec.data),
        .addr_lo (dec.dst[OFF_W-1:0]),
        .wide    (state == ST_WR_STAT),
        .wdata   (pk_wdata),
        .be      (pk_be)
    );

    dma_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .ring_size (ring_size),
        .tail      (tail_ptr),
        .count     (done_count)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (enable && head_ptr != tail_ptr) nxt = ST_FETCH;
            ST_FETCH:   if (mem_ack) nxt = ST_DECODE;
            ST_DECODE: begin
                if (!dec.known) begin
                    nxt = ST_HALT;
                end else begin
                    unique case (dec.op)
                        OP_NOP:  nxt = ST_RETIRE;
                        OP_COPY: nxt = (dec.lines == '0) ? ST_HALT : ST_CP_RD;
                        OP_STAT: nxt = ST_WR_STAT;
                        OP_GEN:  nxt = ST_WR_GEN;
                    endcase
                end
            end
            ST_CP_RD:   if (mem_ack) nxt = ST_CP_WR;
            ST_CP_WR:   if (mem_ack) nxt = (left_q == LEN_W'(1)) ? ST_RETIRE : ST_CP_RD;
            ST_WR_STAT: if (mem_ack) nxt = ST_RETIRE;
            ST_WR_GEN:  if (mem_ack) nxt = ST_RETIRE;
            ST_RETIRE:  nxt = ST_IDLE;
            ST_HALT:    if (!enable) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
            line_q <= '0;
            err_q  <= '0;
        end else begin
            unique case (state)
                ST_FETCH: if (mem_ack) raw_q <= mem_rdata[fetch_slot*DESC_W +: DESC_W];
                ST_DECODE: begin
                    src_q  <= dec.src[DESC_ADDR_W-1:OFF_W];
                    dst_q  <= dec.dst[DESC_ADDR_W-1:OFF_W];
                    left_q <= dec.lines;
                    if (!dec.known)
                        err_q[0] <= 1'b1;
                    else if (dec.op == OP_COPY && dec.lines == '0)
                        err_q[1] <= 1'b1;
                end
                ST_CP_RD: if (mem_ack) line_q <= mem_rdata;
                ST_CP_WR: if (mem_ack) begin
                    src_q  <= src_q + 1'b1;
                    dst_q  <= dst_q + 1'b1;
                    left_q <= left_q - 1'b1;
                end
                ST_HALT: if (!enable) err_q <= '0;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        adv       = 1'b0;
        irq       = 1'b0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = {fetch_byte[DESC_ADDR_W-1:OFF_W], OFF_W'(0)};
            end
            ST_CP_RD: begin
                mem_req  = 1'b1;
                mem_addr = {src_q, OFF_W'(0)};
            end
            ST_CP_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {dst_q, OFF_W'(0)};
                mem_wdata = line_q;
                mem_be    = '1;
            end
            ST_WR_STAT, ST_WR_GEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {dec.dst[DESC_ADDR_W-1:OFF_W], OFF_W'(0)};
                mem_wdata = pk_wdata;
                mem_be    = pk_be;
            end
            ST_RETIRE: begin
                adv = 1'b1;
                irq = dec.known && dec.op == OP_STAT && dec.irq_req;
            end
            default: ;
        endcase
    end

    assign err_flags = err_q;

endmodule

// File: rtl/dma_ring_engine_chk.sv
module dma_ring_engine_chk
    import dma_ring_pkg::*;
#(
    parameter int IDX_W      = 17,
    parameter int LINE_BYTES = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      enable,
    input logic [DESC_ADDR_W-1:0]    ring_base,
    input logic [IDX_W-1:0]          ring_size,
    input logic [IDX_W-1:0]          head_ptr,
    input logic                      mem_req,
    input logic                      mem_we,
    input logic [DESC_ADDR_W-1:0]    mem_addr,
    input logic [LINE_BYTES*8-1:0]   mem_wdata,
    input logic [LINE_BYTES-1:0]     mem_be,
    input logic                      mem_ack,
    input logic [LINE_BYTES*8-1:0]   mem_rdata,
    input logic [IDX_W-1:0]          tail_ptr,
    input logic [IDX_W-1:0]          done_count,
    input logic [1:0]                err_flags,
    input logic                      irq
);

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_be) && $stable(mem_wdata)));

    p_strobe_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 4 || $countones(mem_be) == 8
                                 || $countones(mem_be) == LINE_BYTES));

    p_tail_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_size != '0) |-> (tail_ptr < ring_size));

    p_lockstep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_ptr != $past(tail_ptr)) |-> (done_count == IDX_W'($past(done_count) + 1'b1)));

    p_halt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags != 2'b00) |-> (!mem_req && !irq));

    p_halt_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flags != 2'b00 && $past(err_flags) != 2'b00) |-> $stable(tail_ptr));

    p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

endmodule

bind dma_ring_engine dma_ring_engine_chk #(.IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES)) u_chk (.*);

// File: tb/dma_ring_engine_tb.sv
`timescale 1ns/1ps
module dma_ring_engine_tb;

    localparam int LAT  = 2;
    localparam int RSZ  = 8;
    localparam logic [39:0] BASE = 40'h1000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         enable;
    logic [39:0]  ring_base;
    logic [16:0]  ring_size;
    logic [16:0]  head_ptr;
    logic         mem_req, mem_we;
    logic [39:0]  mem_addr;
    logic [511:0] mem_wdata;
    logic [63:0]  mem_be;
    logic         mem_ack;
    logic [511:0] mem_rdata;
    logic [16:0]  tail_ptr, done_count;
    logic [1:0]   err_flags;
    logic         irq;

    always #2.5 clk = ~clk;

    dma_ring_engine u_dut (.*);

    logic [511:0] mem [256];
    int n_chk = 0, n_bad = 0, irq_seen = 0, hold_err = 0, log_n = 0;
    logic [39:0] log_addr [64];
    logic        log_we   [64];
    bit finished = 0;

    // Memory responder: fixed latency, one request at a time
    initial begin
        int lat;
        logic [39:0] a0;
        lat = 0; a0 = '0;
        mem_ack = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (irq) irq_seen++;
            if (mem_ack) begin
                mem_ack = 1'b0; lat = 0;
            end else if (mem_req) begin
                if (lat == 0) a0 = mem_addr;
                else if (mem_addr !== a0) hold_err++;
                lat++;
                if (lat >= LAT) begin
                    if (mem_we) begin
                        for (int b = 0; b < 64; b++)
                            if (mem_be[b]) mem[mem_addr[13:6]][b*8 +: 8] = mem_wdata[b*8 +: 8];
                    end else begin
                        mem_rdata = mem[mem_addr[13:6]];
                    end
                    if (log_n < 64) begin
                        log_addr[log_n] = mem_addr; log_we[log_n] = mem_we;
                    end
                    log_n++;
                    mem_ack = 1'b1;
                end
            end
        end
    end

    task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(int slot, logic [127:0] d);
        mem[(BASE >> 6) + slot / 4][(slot % 4) * 128 +: 128] = d;
    endtask

    function automatic logic [127:0] mk_nop();
        return 128'h0;
    endfunction
    function automatic logic [127:0] mk_copy(logic [39:0] s, logic [39:0] d, logic [13:0] n);
        return {4'h1, 20'h0, d, 4'h0, n, 6'h0, s};
    endfunction
    function automatic logic [127:0] mk_stat(logic [63:0] v, logic [39:0] d, logic i);
        return {4'h2, i, 19'h0, d, v};
    endfunction
    function automatic logic [127:0] mk_gen(logic [31:0] v, logic [39:0] d);
        return {4'h3, 20'h0, d, 32'h0, v};
    endfunction

    task automatic idle_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tail(string tag, logic [16:0] t);
        int k = 0;
        while (tail_ptr !== t && k < 400) begin @(negedge clk); k++; end
        chk({tag, " tail reached"}, 512'(tail_ptr), 512'(t));
    endtask

    task automatic t_reset();
        chk("R11 tail", 512'(tail_ptr), 0);
        chk("R11 count", 512'(done_count), 0);
        chk("R11 err", 512'(err_flags), 0);
        chk("R11 req", 512'(mem_req), 0);
        chk("R11 irq", 512'(irq), 0);
    endtask

    task automatic t_empty();
        log_n = 0; enable = 1'b1; head_ptr = 17'd0;
        idle_cycles(20);
        chk("R1 no request when empty", 512'(log_n), 0);
    endtask

    task automatic t_nop();
        put_desc(0, mk_nop()); log_n = 0; head_ptr = 17'd1;
        wait_tail("R2 nop", 17'd1);
        chk("R6 count after nop", 512'(done_count), 1);
        chk("R2 only fetch", 512'(log_n), 1);
        chk("R1 fetch address", 512'(log_addr[0]), 512'(BASE));
        chk("R1 fetch is read", 512'(log_we[0]), 0);
    endtask

    task automatic t_gen();
        logic [511:0] e;
        int i0;
        i0 = irq_seen;
        mem[8'hE0] = {64{8'hA5}};
        e = {64{8'hA5}};
        e[4*8 +: 32] = 32'hCAFEF00D;
        put_desc(1, mk_gen(32'hCAFEF00D, 40'h3804));
        head_ptr = 17'd2;
        wait_tail("R5 gen", 17'd2);
        chk("R5 general write bytes 4..7", mem[8'hE0], e);
        chk("R5 no irq", 512'(irq_seen - i0), 0);
    endtask

    task automatic t_stat();
        logic [511:0] e;
        int i0;
        i0 = irq_seen;
        e = mem[8'hE0];
        e[16*8 +: 64] = 64'h1122334455667788;
        e[24*8 +: 64] = 64'h99AABBCCDDEEFF00;
        put_desc(2, mk_stat(64'h1122334455667788, 40'h3810, 1'b1));
        put_desc(3, mk_stat(64'h99AABBCCDDEEFF00, 40'h3818, 1'b0));
        head_ptr = 17'd4;
        wait_tail("R4 stat", 17'd4);
        idle_cycles(2);
        chk("R4 status words placed", mem[8'hE0], e);
        chk("R4 one irq for flagged status only", 512'(irq_seen - i0), 1);
    endtask

    task automatic t_copy();
        for (int k = 0; k < 4; k++) begin
            mem[8'h80 + k] = {16{32'h5A000000 + 32'(k)}};
            mem[8'hC0 + k] = '0;
        end
        put_desc(4, mk_copy(40'h2000, 40'h3000, 14'd3));
        log_n = 0; head_ptr = 17'd5;
        wait_tail("R3 copy", 17'd5);
        chk("R3 access count", 512'(log_n), 7);
        chk("R3 fetch slot 4 line", 512'(log_addr[0]), 512'(40'h1040));
        for (int k = 0; k < 3; k++) begin
            chk("R3 read order", 512'({log_addr[1+2*k], log_we[1+2*k]}), 512'({40'h2000 + 40'(64*k), 1'b0}));
            chk("R3 write order", 512'({log_addr[2+2*k], log_we[2+2*k]}), 512'({40'h3000 + 40'(64*k), 1'b1}));
            chk("R3 line copied", mem[8'hC0 + k], mem[8'h80 + k]);
        end
        chk("R3 no line beyond length", mem[8'hC3], '0);
        chk("R6 count after copy", 512'(done_count), 5);
    endtask

    task automatic t_wrap();
        for (int s = 5; s < RSZ; s++) put_desc(s, mk_nop());
        put_desc(0, mk_nop());
        head_ptr = 17'd1;
        wait_tail("R6 wrap to slot 1", 17'd1);
        chk("R6 count across wrap", 512'(done_count), 9);
    endtask

    task automatic t_bad();
        put_desc(1, {4'h5, 124'h0});
        head_ptr = 17'd2;
        idle_cycles(30);
        chk("R7 bad kind flag", 512'(err_flags), 1);
        chk("R7 tail held", 512'(tail_ptr), 1);
        log_n = 0; idle_cycles(10);
        chk("R7 no requests while halted", 512'(log_n), 0);
        enable = 1'b0; idle_cycles(3);
        chk("R7 flag cleared by disable", 512'(err_flags), 0);
        put_desc(1, mk_nop()); enable = 1'b1;
        wait_tail("R7 resume", 17'd2);
        chk("R7 count after resume", 512'(done_count), 10);
    endtask

    task automatic t_zero();
        put_desc(2, mk_copy(40'h2000, 40'h3000, 14'd0));
        head_ptr = 17'd3;
        idle_cycles(30);
        chk("R8 zero length flag", 512'(err_flags), 2);
        chk("R8 tail held", 512'(tail_ptr), 2);
        enable = 1'b0; idle_cycles(3);
        put_desc(2, mk_nop()); enable = 1'b1;
        wait_tail("R8 resume", 17'd3);
    endtask

    task automatic t_disable();
        enable = 1'b0; idle_cycles(2);
        put_desc(3, mk_nop()); log_n = 0; head_ptr = 17'd4;
        idle_cycles(30);
        chk("R10 no fetch while disabled", 512'(log_n), 0);
        chk("R10 tail held", 512'(tail_ptr), 3);
        enable = 1'b1;
        wait_tail("R10 runs after enable", 17'd4);
        chk("R9 request fields held until ack", 512'(hold_err), 0);
    endtask

    initial begin
        rst_n = 1'b0; enable = 1'b0;
        ring_base = BASE; ring_size = 17'(RSZ); head_ptr = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_nop();
        t_gen();
        t_stat();
        t_copy();
        t_wrap();
        t_bad();
        t_zero();
        t_disable();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule